// File: doc/BRIEF.md
# USB Endpoint Transaction Status Controller

This block keeps the handshake state of every USB endpoint between a serial interface engine and firmware. For each endpoint it holds a small set of status bits, a byte FIFO with a byte counter, and an interrupt request. Firmware selects one endpoint at a time. It reads that endpoint's status and byte count, sets or clears status bits through set and clear masks, and reads or writes the FIFO. The serial engine presents a token (OUT, SETUP or IN) for one endpoint. It gets back a combinational accept (ACK or data) or refusal (NAK), then streams bytes into or out of the FIFO, and closes the packet with a done pulse.

Endpoint 0 is the control endpoint. It takes SETUP packets and switches between receive and transmit through a firmware-written direction bit. Every other endpoint has one direction, fixed by a parameter mask. Bulk, interrupt and isochronous OUT endpoints behave the same way here. A completed SETUP clears all other status of the control endpoint. The FIFO stays with firmware until firmware releases it by clearing the receive flag.

Top module: `usb_ep_status_ctrl`

## Requirements
- R1: After reset, every endpoint has a byte count of 0, no interrupt request, and status bits 0 to 3 at 0. The direction bit (bit 4) reads 1 only on endpoints marked IN in the direction mask (default: endpoint 2).
- R2: A SETUP token (code 2) on endpoint 0 is always accepted. It overwrites any data already in the FIFO. Its done pulse sets the setup flag (bit 2), clears every other status bit including direction, and leaves the byte count equal to the bytes received.
- R3: A SETUP token on any other endpoint is refused and changes nothing.
- R4: When firmware clears a set OUT flag (bit 1) or setup flag (bit 2), the endpoint's byte count returns to 0.
- R5: An OUT token (code 1) is refused while bit 1 or bit 2 is set, on an IN-only endpoint, or on endpoint 0 with the direction bit at 1. A refused OUT leaves the byte count unchanged.
- R6: An accepted OUT packet sets bit 1 when done. The byte count equals the bytes received, and firmware reads them back in arrival order.
- R7: An IN token (code 3) is accepted only while the transmit-ready bit (bit 3) is 1 and the transmit-complete bit (bit 0) is 0. The engine reads the FIFO bytes in write order. Done sets bit 0, clears bit 3 and returns the byte count to 0.
- R8: Firmware can change the direction bit only on endpoint 0. Writes to it on other endpoints have no effect.
- R9: Firmware FIFO writes are ignored while the endpoint is in the receive direction, and once the byte count reaches the endpoint size (16 by default).
- R10: The interrupt request of an endpoint equals its enable input ANDed with the OR of bits 0, 1 and 2.
- R11: Zero-length packets work as status stages. An IN with bit 3 set and an empty FIFO completes with bit 0. An OUT with no bytes sets bit 1 with a byte count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fw_sel_i | input | EPW | Endpoint selected by firmware |
| fw_reg_wr_i | input | 1 | Apply set and clear masks to the selected endpoint |
| fw_set_i | input | 5 | Status bits to set |
| fw_clr_i | input | 5 | Status bits to clear |
| fw_status_o | output | 5 | Status of the selected endpoint |
| fw_bytecnt_o | output | CW | Byte count of the selected endpoint |
| fw_fifo_wr_i | input | 1 | Firmware FIFO write strobe |
| fw_fifo_wdata_i | input | DW | Firmware write byte |
| fw_fifo_rd_i | input | 1 | Firmware FIFO read strobe (advances pointer) |
| fw_fifo_rdata_o | output | DW | Byte at the selected endpoint's read pointer |
| irq_en_i | input | NUM_EP | Per-endpoint interrupt enables |
| irq_o | output | NUM_EP | Per-endpoint interrupt requests |
| sie_ep_i | input | EPW | Endpoint addressed by the serial engine |
| sie_tok_vld_i | input | 1 | Token strobe |
| sie_tok_i | input | 2 | Token kind: 1 OUT, 2 SETUP, 3 IN |
| sie_accept_o | output | 1 | 1 accepts the token, 0 means NAK |
| sie_wr_i | input | 1 | Received byte strobe |
| sie_wdata_i | input | DW | Received byte |
| sie_rd_i | input | 1 | Transmit byte read strobe |
| sie_rdata_o | output | DW | Byte at the addressed endpoint's read pointer |
| sie_done_i | input | 1 | Packet completed successfully |

## Verification
A wrong status register shows up on the engine's side in the same cycle as the next token. A refused OUT that should have been accepted, or a stale transmit-complete bit that blocks an IN, changes sie_accept_o at once. A wrong FIFO pointer or counter shows up in the first byte read back, or in the byte count one cycle after the packet's done pulse. A missed clear on SETUP shows in fw_status_o and in the interrupt line one cycle after done.

// File: rtl/usb_eps_pkg.sv
package usb_eps_pkg;
  localparam int ST_W      = 5;
  localparam int B_TXCMPL  = 0;
  localparam int B_RXOUT   = 1;
  localparam int B_RXSETUP = 2;
  localparam int B_TXRDY   = 3;
  localparam int B_DIR     = 4;

  typedef enum logic [1:0] {
    TK_NONE  = 2'd0,
    TK_OUT   = 2'd1,
    TK_SETUP = 2'd2,
    TK_IN    = 2'd3
  } tok_e;
endpackage

// File: rtl/ep_fifo.sv
module ep_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          rewind_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rd_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [CW-1:0] count_q;
  logic [CW-1:0] rptr_q;
  logic          full;

  assign full = (count_q == CW'(DEPTH));

  always_ff @(posedge clk_i) begin
    if (wr_i && !full && !clr_i) mem_q[PW'(count_q)] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      rptr_q  <= '0;
    end else begin
      if (clr_i) count_q <= '0;
      else if (wr_i && !full) count_q <= count_q + 1'b1;

      if (clr_i || rewind_i) rptr_q <= '0;
      else if (rd_i && (rptr_q < count_q)) rptr_q <= rptr_q + 1'b1;
    end
  end

  assign rdata_o = (rptr_q < CW'(DEPTH)) ? mem_q[PW'(rptr_q)] : '0;
  assign count_o = count_q;

  a_r9_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  a_r9_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !clr_i && full) |=> (count_q == CW'(DEPTH)));
endmodule

// File: rtl/ep_state.sv
module ep_state
  import usb_eps_pkg::*;
#(
  parameter bit IS_CTRL  = 1'b0,
  parameter bit FIXED_IN = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fw_wr_i,
  input  logic [ST_W-1:0] fw_set_i,
  input  logic [ST_W-1:0] fw_clr_i,
  input  logic            tok_vld_i,
  input  tok_e            tok_i,
  input  logic            done_i,
  input  logic            irq_en_i,
  output logic [ST_W-1:0] st_o,
  output logic            accept_o,
  output logic            tx_dir_o,
  output logic            rx_act_o,
  output logic            tx_act_o,
  output logic            fifo_clr_o,
  output logic            rewind_o,
  output logic            irq_o
);
  logic [ST_W-1:0] st_q, st_d;
  tok_e            act_q;
  logic            dir_eff, rx_busy, ok;

  assign dir_eff = IS_CTRL ? st_q[B_DIR] : FIXED_IN;
  assign rx_busy = st_q[B_RXOUT] | st_q[B_RXSETUP];

  always_comb begin
    unique case (tok_i)
      TK_SETUP: ok = IS_CTRL;
      TK_OUT:   ok = !dir_eff && !rx_busy;
      TK_IN:    ok = st_q[B_TXRDY] && !st_q[B_TXCMPL] && !st_q[B_RXSETUP];
      default:  ok = 1'b0;
    endcase
  end
  assign accept_o = tok_vld_i && ok;

  always_comb begin
    st_d = st_q;
    if (fw_wr_i) begin
      st_d[B_TXRDY]   = (st_q[B_TXRDY] | fw_set_i[B_TXRDY]) & ~fw_clr_i[B_TXRDY];
      st_d[B_TXCMPL]  = st_q[B_TXCMPL]  & ~fw_clr_i[B_TXCMPL];
      st_d[B_RXOUT]   = st_q[B_RXOUT]   & ~fw_clr_i[B_RXOUT];
      st_d[B_RXSETUP] = st_q[B_RXSETUP] & ~fw_clr_i[B_RXSETUP];
      if (IS_CTRL) st_d[B_DIR] = (st_q[B_DIR] | fw_set_i[B_DIR]) & ~fw_clr_i[B_DIR];
    end
    if (done_i) begin
      unique case (act_q)
        TK_OUT:   st_d[B_RXOUT] = 1'b1;
        TK_SETUP: begin
          st_d = '0;
          st_d[B_RXSETUP] = 1'b1;
        end
        TK_IN: begin
          st_d[B_TXCMPL] = 1'b1;
          st_d[B_TXRDY]  = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      act_q <= TK_NONE;
    end else begin
      st_q <= st_d;
      if (tok_vld_i)   act_q <= ok ? tok_i : TK_NONE;
      else if (done_i) act_q <= TK_NONE;
    end
  end

  assign fifo_clr_o = (accept_o && (tok_i == TK_OUT || tok_i == TK_SETUP))
                    || (done_i && act_q == TK_IN)
                    || (fw_wr_i && fw_clr_i[B_RXOUT] && st_q[B_RXOUT])
                    || (fw_wr_i && fw_clr_i[B_RXSETUP] && st_q[B_RXSETUP]);
  assign rewind_o = accept_o && (tok_i == TK_IN);
  assign rx_act_o = (act_q == TK_OUT) || (act_q == TK_SETUP);
  assign tx_act_o = (act_q == TK_IN);
  assign tx_dir_o = dir_eff;
  assign st_o     = {dir_eff, st_q[B_TXRDY:0]};
  assign irq_o    = irq_en_i & (st_q[B_TXCMPL] | st_q[B_RXOUT] | st_q[B_RXSETUP]);

  a_r2_setup_wipes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && act_q == TK_SETUP) |=> (st_q == (ST_W'(1) << B_RXSETUP)));
  a_r3_setup_ctrl_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_vld_i && tok_i == TK_SETUP && !IS_CTRL) |-> !accept_o);
  a_r5_out_nak_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tok_vld_i && tok_i == TK_OUT && (st_q[B_RXOUT] || st_q[B_RXSETUP])) |-> !accept_o);
  a_r7_in_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && tok_i == TK_IN) |-> (st_q[B_TXRDY] && !st_q[B_TXCMPL]));
  a_r7_done_sets_cmpl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && act_q == TK_IN) |=> (st_q[B_TXCMPL] && !st_q[B_TXRDY]));
endmodule

// File: rtl/usb_ep_status_ctrl.sv
module usb_ep_status_ctrl
  import usb_eps_pkg::*;
#(
  parameter int               NUM_EP     = 4,
  parameter int               EP_BYTES   = 16,
  parameter int               DW         = 8,
  parameter logic [NUM_EP-1:0] EP_IN_MASK = 4'b0100,
  localparam int              EPW        = (NUM_EP > 1) ? $clog2(NUM_EP) : 1,
  localparam int              CW         = $clog2(EP_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EPW-1:0]    fw_sel_i,
  input  logic              fw_reg_wr_i,
  input  logic [4:0]        fw_set_i,
  input  logic [4:0]        fw_clr_i,
  output logic [4:0]        fw_status_o,
  output logic [CW-1:0]     fw_bytecnt_o,
  input  logic              fw_fifo_wr_i,
  input  logic [DW-1:0]     fw_fifo_wdata_i,
  input  logic              fw_fifo_rd_i,
  output logic [DW-1:0]     fw_fifo_rdata_o,
  input  logic [NUM_EP-1:0] irq_en_i,
  output logic [NUM_EP-1:0] irq_o,
  input  logic [EPW-1:0]    sie_ep_i,
  input  logic              sie_tok_vld_i,
  input  logic [1:0]        sie_tok_i,
  output logic              sie_accept_o,
  input  logic              sie_wr_i,
  input  logic [DW-1:0]     sie_wdata_i,
  input  logic              sie_rd_i,
  output logic [DW-1:0]     sie_rdata_o,
  input  logic              sie_done_i
);
  logic [ST_W-1:0] st_arr   [NUM_EP];
  logic [CW-1:0]   cnt_arr  [NUM_EP];
  logic [DW-1:0]   rd_arr   [NUM_EP];
  logic [NUM_EP-1:0] acc_vec;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic fw_hit, sie_hit;
    logic tx_dir, rx_act, tx_act, f_clr, f_rew;
    logic f_wr, f_rd;
    logic [DW-1:0] f_wdata;

    assign fw_hit  = (fw_sel_i == EPW'(e));
    assign sie_hit = (sie_ep_i == EPW'(e));

    ep_state #(
      .IS_CTRL  (e == 0),
      .FIXED_IN (EP_IN_MASK[e])
    ) u_state (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .fw_wr_i    (fw_reg_wr_i && fw_hit),
      .fw_set_i   (fw_set_i),
      .fw_clr_i   (fw_clr_i),
      .tok_vld_i  (sie_tok_vld_i && sie_hit),
      .tok_i      (tok_e'(sie_tok_i)),
      .done_i     (sie_done_i && sie_hit),
      .irq_en_i   (irq_en_i[e]),
      .st_o       (st_arr[e]),
      .accept_o   (acc_vec[e]),
      .tx_dir_o   (tx_dir),
      .rx_act_o   (rx_act),
      .tx_act_o   (tx_act),
      .fifo_clr_o (f_clr),
      .rewind_o   (f_rew),
      .irq_o      (irq_o[e])
    );

    // engine side takes priority over firmware on the same FIFO
    assign f_wr    = (sie_wr_i && sie_hit && rx_act) || (fw_fifo_wr_i && fw_hit && tx_dir);
    assign f_wdata = (sie_wr_i && sie_hit && rx_act) ? sie_wdata_i : fw_fifo_wdata_i;
    assign f_rd    = (sie_rd_i && sie_hit && tx_act) || (fw_fifo_rd_i && fw_hit && !tx_dir);

    ep_fifo #(
      .DEPTH (EP_BYTES),
      .DW    (DW)
    ) u_fifo (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (f_clr),
      .rewind_i (f_rew),
      .wr_i     (f_wr),
      .wdata_i  (f_wdata),
      .rd_i     (f_rd),
      .rdata_o  (rd_arr[e]),
      .count_o  (cnt_arr[e])
    );
  end

  assign fw_status_o     = st_arr[fw_sel_i];
  assign fw_bytecnt_o    = cnt_arr[fw_sel_i];
  assign fw_fifo_rdata_o = rd_arr[fw_sel_i];
  assign sie_rdata_o     = rd_arr[sie_ep_i];
  assign sie_accept_o    = acc_vec[sie_ep_i];

  a_r10_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~irq_en_i) == '0);
  a_r2_one_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(acc_vec));
endmodule

// File: tb/tb_usb_ep_status_ctrl.sv
module tb_usb_ep_status_ctrl;
  localparam int NEP = 4, SZ = 16;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic [1:0] fw_sel = 0, sie_ep = 0, sie_tok = 0;
  logic fw_reg_wr = 0, fw_fifo_wr = 0, fw_fifo_rd = 0;
  logic sie_tok_vld = 0, sie_wr = 0, sie_rd = 0, sie_done = 0;
  logic [4:0] fw_set = 0, fw_clr = 0, fw_status;
  logic [4:0] fw_bytecnt;
  logic [7:0] fw_wdata = 0, fw_rdata, sie_wdata = 0, sie_rdata;
  logic [3:0] irq_en = 0, irq;
  logic sie_acc;

  usb_ep_status_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .fw_sel_i(fw_sel), .fw_reg_wr_i(fw_reg_wr),
    .fw_set_i(fw_set), .fw_clr_i(fw_clr), .fw_status_o(fw_status),
    .fw_bytecnt_o(fw_bytecnt), .fw_fifo_wr_i(fw_fifo_wr), .fw_fifo_wdata_i(fw_wdata),
    .fw_fifo_rd_i(fw_fifo_rd), .fw_fifo_rdata_o(fw_rdata), .irq_en_i(irq_en),
    .irq_o(irq), .sie_ep_i(sie_ep), .sie_tok_vld_i(sie_tok_vld), .sie_tok_i(sie_tok),
    .sie_accept_o(sie_acc), .sie_wr_i(sie_wr), .sie_wdata_i(sie_wdata),
    .sie_rd_i(sie_rd), .sie_rdata_o(sie_rdata), .sie_done_i(sie_done));

  int checks = 0, errors = 0;
  logic [4:0] est [NEP];
  logic [7:0] edat [NEP][SZ];
  int ecnt [NEP];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_acc(int e, int k);
    bit dir = est[e][4];
    case (k)
      2: return e == 0;
      1: return !dir && !est[e][1] && !est[e][2];
      3: return est[e][3] && !est[e][0] && !est[e][2];
      default: return 0;
    endcase
  endfunction

  function automatic bit exp_irq(int e, bit en);
    return en && (|est[e][2:0]);
  endfunction

  task automatic fw_reg(int e, logic [4:0] s, logic [4:0] c);
    @(negedge clk); fw_sel = 2'(e); fw_set = s; fw_clr = c; fw_reg_wr = 1;
    @(posedge clk); #1 fw_reg_wr = 0;
    if (e == 0) est[e][4] = (est[e][4] | s[4]) & ~c[4];
    est[e][3] = (est[e][3] | s[3]) & ~c[3];
    if ((c[1] && est[e][1]) || (c[2] && est[e][2])) ecnt[e] = 0;
    est[e][2:0] = est[e][2:0] & ~c[2:0];
  endtask

  task automatic fw_push(int e, logic [7:0] b);
    @(negedge clk); fw_sel = 2'(e); fw_wdata = b; fw_fifo_wr = 1;
    @(posedge clk); #1 fw_fifo_wr = 0;
    if (est[e][4] && ecnt[e] < SZ) begin edat[e][ecnt[e]] = b; ecnt[e]++; end
  endtask

  task automatic fw_pop(int e, output logic [7:0] b);
    @(negedge clk); fw_sel = 2'(e); fw_fifo_rd = 1; #1 b = fw_rdata;
    @(posedge clk); #1 fw_fifo_rd = 0;
  endtask

  task automatic peek(int e, string req);
    @(negedge clk); fw_sel = 2'(e); #1;
    chk({req, " status"}, fw_status, est[e]);
    chk({req, " bytecnt"}, fw_bytecnt, ecnt[e]);
  endtask

  task automatic token(int e, int k, string req, output bit acc);
    bit exp = exp_acc(e, k);
    @(negedge clk); sie_ep = 2'(e); sie_tok = 2'(k); sie_tok_vld = 1; #1 acc = sie_acc;
    @(posedge clk); #1 sie_tok_vld = 0;
    chk({req, " accept"}, acc, exp);
    if (exp && k != 3) ecnt[e] = 0;
  endtask

  task automatic sie_push(int e, logic [7:0] b);
    @(negedge clk); sie_ep = 2'(e); sie_wdata = b; sie_wr = 1;
    @(posedge clk); #1 sie_wr = 0;
    if (ecnt[e] < SZ) begin edat[e][ecnt[e]] = b; ecnt[e]++; end
  endtask

  task automatic sie_pop(int e, output logic [7:0] b);
    @(negedge clk); sie_ep = 2'(e); sie_rd = 1; #1 b = sie_rdata;
    @(posedge clk); #1 sie_rd = 0;
  endtask

  task automatic done(int e, int k);
    @(negedge clk); sie_ep = 2'(e); sie_done = 1;
    @(posedge clk); #1 sie_done = 0;
    case (k)
      1: est[e][1] = 1;
      2: begin est[e] = 5'b00100; end
      3: begin est[e][0] = 1; est[e][3] = 0; ecnt[e] = 0; end
      default: ;
    endcase
  endtask

  task automatic rx_pkt(int e, int k, int len, string req);
    bit acc;
    token(e, k, req, acc);
    if (acc) begin
      for (int i = 0; i < len; i++) sie_push(e, 8'($urandom));
      done(e, k);
    end
    peek(e, req);
  endtask

  task automatic readback(int e, string req);
    logic [7:0] b;
    for (int i = 0; i < ecnt[e]; i++) begin
      fw_pop(e, b); chk({req, " data"}, b, edat[e][i]);
    end
  endtask

  task automatic tx_pkt(int e, int len, string req);
    bit acc;
    logic [7:0] b;
    int n;
    for (int i = 0; i < len; i++) fw_push(e, 8'($urandom));
    peek(e, "R9 fill");
    n = ecnt[e];
    fw_reg(e, 5'b01000, 5'b0);
    token(e, 3, req, acc);
    for (int i = 0; i < n; i++) begin
      sie_pop(e, b); chk({req, " in data"}, b, edat[e][i]);
    end
    done(e, 3);
    peek(e, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    bit acc;
    logic [7:0] b;
    void'($urandom(32'd20240611));
    for (int e = 0; e < NEP; e++) begin est[e] = (e == 2) ? 5'b10000 : 5'b0; ecnt[e] = 0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    for (int e = 0; e < NEP; e++) peek(e, "R1 reset");
    #1 chk("R1 irq", irq, 0);

    irq_en = 4'b1111;
    rx_pkt(0, 2, 8, "R2 setup");
    #1 chk("R10 irq setup", irq[0], 1);
    rx_pkt(0, 1, 3, "R5 out while setup");
    fw_reg(0, 5'b11000, 5'b0);
    peek(0, "R2 bits before resetup");
    rx_pkt(0, 2, 8, "R2 setup overwrite");
    readback(0, "R2");
    fw_reg(0, 5'b0, 5'b00100);
    peek(0, "R4 clear setup");
    #1 chk("R10 irq cleared", irq[0], 0);

    fw_reg(0, 5'b10000, 5'b0);
    for (int i = 0; i < 5; i++) fw_push(0, 8'(8'h30 + i));
    token(0, 3, "R7 in without txrdy", acc);
    tx_pkt(0, 0, "R7 ctrl in");
    token(0, 3, "R7 in while txcmpl", acc);
    rx_pkt(0, 1, 2, "R5 out with dir set");
    fw_reg(0, 5'b0, 5'b10001);

    fw_reg(0, 5'b01000, 5'b0);
    token(0, 3, "R11 zlp in", acc);
    done(0, 3);
    peek(0, "R11 zlp in");
    fw_reg(0, 5'b0, 5'b00001);
    rx_pkt(0, 1, 0, "R11 zlp out");
    fw_reg(0, 5'b0, 5'b00010);

    rx_pkt(1, 2, 4, "R3 setup on ep1");
    rx_pkt(2, 1, 4, "R5 out on in ep");
    fw_reg(1, 5'b10000, 5'b0);
    peek(1, "R8 dir ep1");
    fw_reg(2, 5'b0, 5'b10000);
    peek(2, "R8 dir ep2");
    fw_push(1, 8'hAA);
    peek(1, "R9 write on rx ep");
    tx_pkt(2, 20, "R9 capped in");
    fw_reg(2, 5'b0, 5'b00001);

    for (int it = 0; it < 40; it++) begin
      int e = 1 + int'($urandom % 3);
      int len = int'($urandom % 21);
      irq_en = 4'($urandom);
      if (e == 2) begin
        tx_pkt(2, len, "R7 rand in");
        #1 chk("R10 rand irq", irq[2], exp_irq(2, irq_en[2]));
        fw_reg(2, 5'b0, 5'b00001);
      end else begin
        rx_pkt(e, 1, len, "R6 rand out");
        #1 chk("R10 rand irq", irq[e], exp_irq(e, irq_en[e]));
        if ($urandom % 3 != 0) begin
          readback(e, "R6");
          fw_reg(e, 5'b0, 5'b00010);
          peek(e, "R4 rand clear");
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule